// File: doc/BRIEF.md
# Cascaded Sub-Interrupt Pending Controller

This block sits in front of a primary interrupt controller and handles eleven secondary interrupt sources that share a small number of primary request lines. Each secondary source is edge-detected. A rising edge latches a bit in a sub-pending register. A sub-mask register then decides which latched bits may reach the primary side. The secondary indices 0 to 10 sit above a primary space of 32 lines, so the whole interrupt space is 43 entries wide.

The unmasked pending bits are ORed in fixed groups. Three groups cover the receive, transmit and error requests of three serial ports. The fourth group joins the touch-screen request and the conversion-done request of an A/D converter. Software works through a small register port. It reads the raw pending vector, clears chosen bits by writing ones, and reads or writes the mask. Each primary request is a registered level that stays high while its group holds an unmasked pending bit.

Top module: `subirq_fold`

## Requirements
- R1: Reset is synchronous and active high. While it is applied, and in the first cycle after it, every pending bit reads 0, every mask bit reads 1 (mask reads 0x000007FF), and all four primary outputs are 0.
- R2: A 0-to-1 change of `src_in[i]` between two clock edges sets pending bit i at the second edge, whether or not bit i is masked. A source held high does not set its bit again.
- R3: A write to byte offset 0x18 clears every pending bit whose write-data bit is 1. Bits written 0 are left unchanged.
- R4: If a rising edge on source i arrives in the same cycle as a clear of pending bit i, the bit ends up set.
- R5: Byte offset 0x1c holds the 11-bit mask (bit i masks source i) and can be written and read back. Data bits 31 down to 11 are ignored on write and read as 0.
- R6: A read of offset 0x18 returns the 11 pending bits in data bits 10 to 0 (bit i is source i), and 0 in bits 31 to 11.
- R7: `irq_out[0]` covers sources 0 to 2, `irq_out[1]` covers sources 3 to 5, `irq_out[2]` covers sources 6 to 8, and `irq_out[3]` covers sources 9 and 10. Each bit is 1 exactly when at least one of its sources is pending and unmasked.
- R8: The primary outputs are registered. They change at the same clock edge as the pending and mask state they follow. A mask bit only gates: unmasking an already pending bit raises its group output at the write edge, and masking it drops the output at that edge.
- R9: A write to any other offset in the 0x20-byte window changes nothing, and a read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 11 | Secondary source request levels |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| irq_out | output | 4 | Grouped primary requests |

## Verification
A new rising edge on a source and a software write-one-to-clear of the same pending bit can fall in the same cycle. The directed part of the bench lines them up on purpose: it raises a source in the very cycle that clears that bit, and it also clears a neighbour bit of the same group in that cycle. After the edge, the bench reads the pending register and the group output. It expects the raised bit to stay set and the neighbour to be gone. The random phase toggles sources while writes hit the pending, mask and unused offsets. That produces many more such collisions, and every one is judged against a bench model of the register state.

// File: rtl/subirq_pkg.sv
package subirq_pkg;

    localparam int SRC_N    = 11;
    localparam int GRP_N    = 4;
    localparam int PER_GRP  = 3;
    localparam int PRI_BASE = 32;
    localparam int IRQ_SPAN = PRI_BASE + SRC_N;

    localparam logic [4:0] OFS_PEND = 5'h18;
    localparam logic [4:0] OFS_MASK = 5'h1c;

    typedef logic [SRC_N-1:0] src_vec_t;
    typedef logic [GRP_N-1:0] grp_vec_t;

    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_PEND = 2'd1,
        RSEL_MASK = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic     clr_en;
        src_vec_t clr_bits;
        logic     mask_en;
        src_vec_t mask_val;
    } bank_cmd_t;

    typedef struct packed {
        src_vec_t pend;
        src_vec_t mask;
    } bank_state_t;

    function automatic int grp_of(input int s);
        if (s < (GRP_N - 1) * PER_GRP)
            return s / PER_GRP;
        return GRP_N - 1;
    endfunction

    function automatic src_vec_t grp_members(input int g);
        src_vec_t m;
        m = '0;
        for (int s = 0; s < SRC_N; s++)
            if (grp_of(s) == g) m[s] = 1'b1;
        return m;
    endfunction

    function automatic reg_sel_e decode(input logic [4:0] ofs);
        case (ofs)
            OFS_PEND: return RSEL_PEND;
            OFS_MASK: return RSEL_MASK;
            default:  return RSEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/subirq_edge.sv
module subirq_edge #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] prev,
    output logic [W-1:0] rise
);

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;

endmodule

// File: rtl/subirq_bank.sv
module subirq_bank
    import subirq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  src_vec_t    rise,
    input  bank_cmd_t   cmd,
    output bank_state_t cur,
    output bank_state_t nxt
);

    bank_state_t st_q;

    always_comb begin
        nxt = st_q;
        if (cmd.clr_en)
            nxt.pend = st_q.pend & ~cmd.clr_bits;
        // a fresh edge outranks a clear of the same bit
        nxt.pend = nxt.pend | rise;
        if (cmd.mask_en)
            nxt.mask = cmd.mask_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pend <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= nxt;
        end
    end

    assign cur = st_q;

endmodule

// File: rtl/subirq_grp_or.sv
module subirq_grp_or
    import subirq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  bank_state_t nxt,
    output grp_vec_t    irq
);

    src_vec_t live;
    grp_vec_t irq_d;
    grp_vec_t irq_q;

    assign live = nxt.pend & ~nxt.mask;

    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        always_comb irq_d[g] = |(live & grp_members(g));
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= '0;
        else     irq_q <= irq_d;
    end

    assign irq = irq_q;

endmodule

// File: rtl/subirq_regif.sv
module subirq_regif
    import subirq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  bank_state_t       cur,
    output bank_cmd_t         cmd,
    output logic [DATA_W-1:0] rdata
);

    localparam int PAD_W = DATA_W - SRC_N;

    reg_sel_e which;
    src_vec_t wbits;
    logic     unused_hi;

    assign which     = decode(addr[4:0]);
    assign wbits     = wdata[SRC_N-1:0];
    assign unused_hi = ^wdata[DATA_W-1:SRC_N];

    always_comb begin
        cmd.clr_en   = sel && wr && (which == RSEL_PEND);
        cmd.clr_bits = wbits;
        cmd.mask_en  = sel && wr && (which == RSEL_MASK);
        cmd.mask_val = wbits;
    end

    always_comb begin
        rdata = '0;
        if (sel && !wr) begin
            case (which)
                RSEL_PEND: rdata = {{PAD_W{1'b0}}, cur.pend};
                RSEL_MASK: rdata = {{PAD_W{1'b0}}, cur.mask};
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/subirq_fold.sv
module subirq_fold
    import subirq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_N-1:0]  src_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [GRP_N-1:0]  irq_out
);

    src_vec_t    src_prev;
    src_vec_t    src_rise;
    bank_cmd_t   cmd;
    bank_state_t st_cur;
    bank_state_t st_nxt;
    src_vec_t    pend_q;
    src_vec_t    mask_q;

    subirq_edge #(.W(SRC_N)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (src_in),
        .prev (src_prev),
        .rise (src_rise)
    );

    subirq_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
        .sel   (bus_sel),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .cur   (st_cur),
        .cmd   (cmd),
        .rdata (bus_rdata)
    );

    subirq_bank u_bank (
        .clk  (clk),
        .rst  (rst),
        .rise (src_rise),
        .cmd  (cmd),
        .cur  (st_cur),
        .nxt  (st_nxt)
    );

    subirq_grp_or u_or (
        .clk (clk),
        .rst (rst),
        .nxt (st_nxt),
        .irq (irq_out)
    );

    assign pend_q = st_cur.pend;
    assign mask_q = st_cur.mask;

endmodule

// File: rtl/subirq_fold_chk.sv
module subirq_fold_chk
    import subirq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [SRC_N-1:0] src_in,
    input logic [SRC_N-1:0] src_prev,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [4:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic [SRC_N-1:0] pend_q,
    input logic [SRC_N-1:0] mask_q,
    input logic [GRP_N-1:0] irq_out
);

    logic [SRC_N-1:0] rise_c;
    logic             clr_c;
    logic             mwr_c;

    assign rise_c = src_in & ~src_prev;
    assign clr_c  = bus_sel && bus_wr && (bus_addr == OFS_PEND);
    assign mwr_c  = bus_sel && bus_wr && (bus_addr == OFS_MASK);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (pend_q == '0 && mask_q == '1 && irq_out == '0));

    assert_edge_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (rise_c != '0) |=> ((pend_q & $past(rise_c)) == $past(rise_c)));

    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        clr_c |=> ((pend_q & $past(bus_wdata[SRC_N-1:0] & ~rise_c)) == '0));

    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
        (!clr_c && rise_c == '0) |=> $stable(pend_q));

    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !mwr_c |=> $stable(mask_q));

    assert_pend_read_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == OFS_PEND) |->
            (bus_rdata == {{(32-SRC_N){1'b0}}, pend_q}));

    assert_group_or_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_out[0] == |(pend_q[2:0] & ~mask_q[2:0])) &&
        (irq_out[1] == |(pend_q[5:3] & ~mask_q[5:3])) &&
        (irq_out[2] == |(pend_q[8:6] & ~mask_q[8:6])) &&
        (irq_out[3] == |(pend_q[10:9] & ~mask_q[10:9])));

    assert_other_read_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr != OFS_PEND && bus_addr != OFS_MASK) |->
            (bus_rdata == '0));

endmodule

bind subirq_fold subirq_fold_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_in    (src_in),
    .src_prev  (src_prev),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pend_q    (pend_q),
    .mask_q    (mask_q),
    .irq_out   (irq_out)
);

// File: tb/sim_subirq_fold.sv
`timescale 1ns/1ps
module sim_subirq_fold;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] src_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [10:0] m_pend, m_mask, m_prev;

    always #10 clk = ~clk;

    subirq_fold u0 (
        .clk(clk), .rst(rst), .src_in(src_in), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic logic [3:0] exp_irq(input logic [10:0] p, input logic [10:0] m);
        logic [3:0] r;
        logic [10:0] live;
        live = p & ~m;
        r[0] = live[0] | live[1] | live[2];
        r[1] = live[3] | live[4] | live[5];
        r[2] = live[6] | live[7] | live[8];
        r[3] = live[9] | live[10];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: drive, let edge pass, update model
    task automatic step(input logic [10:0] s, input logic w, input logic [4:0] a,
                        input logic [31:0] d);
        logic [10:0] rise;
        src_in = s; bus_sel = w; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        rise = s & ~m_prev;
        if (w && a == 5'h18) m_pend = m_pend & ~d[10:0];
        m_pend = m_pend | rise;
        if (w && a == 5'h1c) m_mask = d[10:0];
        m_prev = s;
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1; v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic check_all(input string req);
        logic [31:0] v;
        rd(5'h18, v); check({req, " pend"}, v, {21'd0, m_pend});
        rd(5'h1c, v); check({req, " mask"}, v, {21'd0, m_mask});
        check({req, " irq"}, {28'd0, irq_out}, {28'd0, exp_irq(m_pend, m_mask)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [10:0] s;
        int unsigned seed;
        seed = 32'd5150;
        void'($urandom(seed));
        m_pend = '0; m_mask = '1; m_prev = '0;

        repeat (3) @(posedge clk);
        #1;
        // R1: state during reset
        rd(5'h1c, v); check("R1 mask in reset", v, 32'h7FF);
        rd(5'h18, v); check("R1 pend in reset", v, 32'h0);
        check("R1 irq in reset", {28'd0, irq_out}, 32'h0);
        rst = 1'b0;
        step(11'h0, 0, 5'h0, 0);
        check_all("R1");

        // R2: edge while masked latches, irq stays low
        step(11'h001, 0, 5'h0, 0);
        check_all("R2 masked edge");
        check("R2 pend bit0", {31'd0, m_pend[0]}, 32'h1);
        // R8: unmask pending bit -> group 0 rises at the write edge
        step(11'h001, 1, 5'h1c, 32'hFFFF_F800);
        check("R8 unmask irq", {28'd0, irq_out}, 32'h1);
        check_all("R8");
        // R5: upper mask bits ignored
        rd(5'h1c, v); check("R5 mask upper zero", v, 32'h0);
        // R3: clear while source held high, no retrigger (R2)
        step(11'h001, 1, 5'h18, 32'h1);
        check("R3 cleared", {28'd0, irq_out}, 32'h0);
        step(11'h001, 0, 5'h0, 0);
        check("R2 no retrigger", {28'd0, irq_out}, 32'h0);
        check_all("R3");
        // R7: each group alone
        for (int g = 0; g < 4; g++) begin
            s = (g < 3) ? (11'h2 << (3*g)) : 11'h400;
            step(11'h0, 0, 5'h0, 0);
            step(s, 0, 5'h0, 0);
            check("R7 group alone", {28'd0, irq_out}, {28'd0, 4'b1 << g});
            step(s, 1, 5'h18, 32'h7FF);
            check_all("R7");
        end
        // R4: set beats clear, neighbour cleared (R3 write-0 leaves others)
        step(11'h000, 0, 5'h0, 0);
        step(11'h004, 0, 5'h0, 0);
        step(11'h002, 1, 5'h18, 32'h6);
        rd(5'h18, v); check("R4 set wins", v, 32'h2);
        check("R4 irq", {28'd0, irq_out}, 32'h1);
        check_all("R4");
        // R8: re-mask drops output
        step(11'h002, 1, 5'h1c, 32'h002);
        check("R8 mask drops irq", {28'd0, irq_out}, 32'h0);
        // R6: read pending with upper zero
        rd(5'h18, v); check("R6 pend raw", v, 32'h2);
        // R9: other offsets ignored on write, zero on read
        step(11'h002, 1, 5'h00, 32'hFFFF_FFFF);
        step(11'h002, 1, 5'h14, 32'hFFFF_FFFF);
        rd(5'h00, v); check("R9 read other", v, 32'h0);
        rd(5'h10, v); check("R9 read other", v, 32'h0);
        check_all("R9");

        // random phase
        for (int i = 0; i < 400; i++) begin
            logic [4:0] a;
            logic       w;
            int         k;
            k = $urandom_range(0, 5);
            a = (k < 2) ? 5'h18 : (k < 4) ? 5'h1c : 5'($urandom_range(0, 7) * 4);
            w = ($urandom_range(0, 2) == 0);
            step(11'($urandom), w, a, $urandom);
            check_all("R7 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule